// File: doc/BRIEF.md
# Dual-Mask Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines and presents them to a processor as two request outputs: a normal request and a fast request. Each output has its own enable mask over the same set of sources. A source counts as pending while its input is high or while its software-trigger bit is set. No acknowledge write is needed: a source stops being pending as soon as its level falls.

Software reaches the block through a single-cycle word-addressed register port. It changes the enable masks and the software-trigger bits only through separate set and clear registers. In each of these registers, a 1 bit acts and a 0 bit leaves that position alone. Reads are combinational, so a status read always shows the live input levels. A handler can read the masked status, service the lowest set bit, and read again until the value is zero. A parameter names which source positions exist. Every other position reads as zero everywhere.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: After reset, both enable masks and the software-trigger register are zero, and `irq_o` and `fiq_o` are low.
- R2: A write to word 2 (byte 0x08) sets each normal-request enable bit whose data bit is 1 and leaves every other enable bit unchanged. A read of word 2 returns the normal-request enable mask.
- R3: A write to word 3 (byte 0x0C) clears each normal-request enable bit whose data bit is 1. A write to word 11 (byte 0x2C) does the same on the fast-request mask. Reads of words 3, 11 and 5 return zero.
- R4: A write to word 10 (byte 0x28) sets fast-request enable bits in the same way as R2. A read of word 10 returns the fast-request mask. Writes to either mask never change the other mask.
- R5: A write to word 4 (byte 0x10) sets each software-trigger bit whose data bit is 1. A write to word 5 (byte 0x14) clears each such bit. A read of word 4 returns the software-trigger register.
- R6: Words 1 and 9 (bytes 0x04 and 0x24) read the raw status, which is `src_in` OR the software-trigger register. The read follows `src_in` in the same cycle, with no clock edge in between.
- R7: Word 0 (byte 0x00) reads the raw status AND the normal-request mask. Word 8 (byte 0x20) reads the raw status AND the fast-request mask.
- R8: On every clock edge, `irq_o` takes the OR of all bits of the word 0 value, and `fiq_o` takes the OR of all bits of the word 8 value. Each output therefore follows its status one cycle later.
- R9: Writes to words 0, 1, 8 and 9, and to unmapped words 6, 7 and 12 to 15, change no state. Reads of unmapped words return zero.
- R10: Bit positions that are 0 in `VALID_MASK` read as zero in every register. They never raise either request output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe; the write takes effect at the clock edge |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| src_in | input | 32 | Level-sensitive interrupt inputs |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
The bench sends random writes to all sixteen word addresses, mixed with random source patterns, and keeps its own model of both masks and the trigger register. After every step it reads back all sixteen words and both request lines. This exposes a set register that clobbers 0 bits, a mask leaking into the wrong output, and a write landing on a read-only or unmapped word. Directed cases follow. A source that changes between clock edges separates a live raw status from a registered one. The same source enabled in only one mask shows whether the two outputs are independent. An all-ones write shows whether the valid-source mask suppresses the positions that do not exist.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
  localparam int DW = 32;
  localparam int AW = 4;

  localparam logic [AW-1:0] W_IRQ_STAT = 4'd0;
  localparam logic [AW-1:0] W_RAW_A    = 4'd1;
  localparam logic [AW-1:0] W_IRQ_SET  = 4'd2;
  localparam logic [AW-1:0] W_IRQ_CLR  = 4'd3;
  localparam logic [AW-1:0] W_SW_SET   = 4'd4;
  localparam logic [AW-1:0] W_SW_CLR   = 4'd5;
  localparam logic [AW-1:0] W_FIQ_STAT = 4'd8;
  localparam logic [AW-1:0] W_RAW_B    = 4'd9;
  localparam logic [AW-1:0] W_FIQ_SET  = 4'd10;
  localparam logic [AW-1:0] W_FIQ_CLR  = 4'd11;

  // next value of a set/clear register
  function automatic logic [DW-1:0] w1sc_next(input logic [DW-1:0] cur,
                                              input logic [DW-1:0] bits,
                                              input logic do_set,
                                              input logic do_clr,
                                              input logic [DW-1:0] valid);
    logic [DW-1:0] v;
    v = cur;
    if (do_set) v = v | bits;
    if (do_clr) v = v & ~bits;
    return v & valid;
  endfunction

  function automatic logic [DW-1:0] gate(input logic [DW-1:0] raw,
                                         input logic [DW-1:0] en);
    return raw & en;
  endfunction
endpackage

// File: rtl/ictl_w1sc_reg.sv
module ictl_w1sc_reg
  import ictl_pkg::*;
#(
  parameter logic [DW-1:0] VALID = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic [DW-1:0] bits,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= w1sc_next(q, bits, set_we, clr_we, VALID);
  end

  assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((q & $past(bits) & VALID) == ($past(bits) & VALID)));
  assert_clr_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((q & $past(bits)) == '0));
  assert_zero_bits_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we || clr_we) |=> ((q & ~$past(bits)) == ($past(q) & ~$past(bits))));
  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(q));
endmodule

// File: rtl/ictl_readmux.sv
module ictl_readmux
  import ictl_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] raw,
  input  logic [DW-1:0] irq_en,
  input  logic [DW-1:0] fiq_en,
  input  logic [DW-1:0] sw_q,
  output logic [DW-1:0] rdata
);
  always_comb begin
    unique case (addr)
      W_IRQ_STAT:       rdata = gate(raw, irq_en);
      W_RAW_A, W_RAW_B: rdata = raw;
      W_IRQ_SET:        rdata = irq_en;
      W_SW_SET:         rdata = sw_q;
      W_FIQ_STAT:       rdata = gate(raw, fiq_en);
      W_FIQ_SET:        rdata = fiq_en;
      default:          rdata = '0;
    endcase
  end
endmodule

// File: rtl/ictl_reqout.sv
module ictl_reqout
  import ictl_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0][DW-1:0]  stat,
  output logic [LANES-1:0]          req
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic any_pend;
    assign any_pend = |stat[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req[g] <= 1'b0;
      else        req[g] <= any_pend;
    end
    assert_req_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (req[g] == $past(stat[g] != '0)));
  end
endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
  import ictl_pkg::*;
#(
  parameter logic [31:0] VALID_MASK = 32'h7FFF_FFEF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] src_in,
  output logic        irq_o,
  output logic        fiq_o
);
  logic [DW-1:0] irq_en, fiq_en, sw_q, raw;
  logic [1:0][DW-1:0] stat;
  logic [1:0] req;

  // decoded write events, named for the assertions
  logic wr_irq_set, wr_irq_clr, wr_fiq_set, wr_fiq_clr, wr_sw_set, wr_sw_clr;
  assign wr_irq_set = bus_wr && (bus_addr == W_IRQ_SET);
  assign wr_irq_clr = bus_wr && (bus_addr == W_IRQ_CLR);
  assign wr_fiq_set = bus_wr && (bus_addr == W_FIQ_SET);
  assign wr_fiq_clr = bus_wr && (bus_addr == W_FIQ_CLR);
  assign wr_sw_set  = bus_wr && (bus_addr == W_SW_SET);
  assign wr_sw_clr  = bus_wr && (bus_addr == W_SW_CLR);

  ictl_w1sc_reg #(.VALID(VALID_MASK)) u_irq_en (
    .clk(clk), .rst_n(rst_n), .set_we(wr_irq_set), .clr_we(wr_irq_clr),
    .bits(bus_wdata), .q(irq_en));
  ictl_w1sc_reg #(.VALID(VALID_MASK)) u_fiq_en (
    .clk(clk), .rst_n(rst_n), .set_we(wr_fiq_set), .clr_we(wr_fiq_clr),
    .bits(bus_wdata), .q(fiq_en));
  ictl_w1sc_reg #(.VALID(VALID_MASK)) u_sw (
    .clk(clk), .rst_n(rst_n), .set_we(wr_sw_set), .clr_we(wr_sw_clr),
    .bits(bus_wdata), .q(sw_q));

  assign raw     = (src_in | sw_q) & VALID_MASK;
  assign stat[0] = gate(raw, irq_en);
  assign stat[1] = gate(raw, fiq_en);

  ictl_readmux u_rd (
    .addr(bus_addr), .raw(raw), .irq_en(irq_en), .fiq_en(fiq_en),
    .sw_q(sw_q), .rdata(bus_rdata));

  ictl_reqout #(.LANES(2)) u_req (
    .clk(clk), .rst_n(rst_n), .stat(stat), .req(req));

  assign irq_o = req[0];
  assign fiq_o = req[1];

  // IRQ mask writes never touch the FIQ mask and vice versa
  assert_mask_indep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_irq_set || wr_irq_clr) |=> $stable(fiq_en));
  assert_mask_indep_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fiq_set || wr_fiq_clr) |=> $stable(irq_en));
  assert_unused_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rdata & ~VALID_MASK) == '0));
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq_o && !fiq_o));
endmodule

// File: tb/irq_fiq_ctrl_test.sv
module irq_fiq_ctrl_test;
  localparam int CLK_PERIOD = 40;
  localparam logic [31:0] VM = 32'h7FFF_FFEF;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, src_in = '0, bus_rdata;
  logic irq_o, fiq_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [31:0] m_ien = '0, m_fen = '0, m_sw = '0;

  irq_fiq_ctrl #(.VALID_MASK(VM)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .irq_o(irq_o), .fiq_o(fiq_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] m_raw();
    return (src_in | m_sw) & VM;
  endfunction

  function automatic logic [31:0] exp_rd(input int a);
    case (a)
      0: return m_raw() & m_ien;
      1, 9: return m_raw();
      2: return m_ien;
      4: return m_sw;
      8: return m_raw() & m_fen;
      10: return m_fen;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      0, 8: return "R7";
      1, 9: return "R6";
      2: return "R2";
      3, 11: return "R3";
      10: return "R4";
      4, 5: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called in the low phase; reads are combinational (R10 holds through model masking)
  task automatic check_all(input string outtag);
    for (int a = 0; a < 16; a++) begin
      bus_addr = 4'(a);
      #1;
      chk(bus_rdata, exp_rd(a), tag_of(a));
    end
    chk({31'b0, irq_o}, {31'b0, |(m_raw() & m_ien)}, outtag);
    chk({31'b0, fiq_o}, {31'b0, |(m_raw() & m_fen)}, outtag);
  endtask

  task automatic do_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(posedge clk);
    case (a)
      2: m_ien = (m_ien | d) & VM;
      3: m_ien = m_ien & ~d;
      4: m_sw = (m_sw | d) & VM;
      5: m_sw = m_sw & ~d;
      10: m_fen = (m_fen | d) & VM;
      11: m_fen = m_fen & ~d;
      default: ;
    endcase
    @(negedge clk);
    bus_wr = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check_all("R8");
  endtask

  task automatic do_src(input logic [31:0] v);
    @(negedge clk);
    src_in = v;
    bus_addr = 4'd1;
    #1;
    chk(bus_rdata, (v | m_sw) & VM, "R6 live");
    @(posedge clk);
    @(negedge clk);
    check_all("R8");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check_all("R1");

    // R4: same source, enabled only in one mask
    do_write(2, 32'h0000_0008);
    do_src(32'h0000_0008);
    chk({31'b0, irq_o}, 32'd1, "R4 irq");
    chk({31'b0, fiq_o}, 32'd0, "R4 fiq");
    do_write(10, 32'h0000_0100);
    do_write(3, 32'h0000_0008);
    chk({31'b0, irq_o}, 32'd0, "R3 irq off");
    // R9: writes to status words ignored
    do_write(0, 32'hFFFF_FFFF);
    do_write(9, 32'hFFFF_FFFF);
    do_write(13, 32'hFFFF_FFFF);
    // R10: all-ones into every set register
    do_write(2, 32'hFFFF_FFFF);
    bus_addr = 4'd2; #1;
    chk(bus_rdata, VM, "R10 irq en");
    do_write(4, 32'hFFFF_FFFF);
    do_src(32'h0);
    bus_addr = 4'd1; #1;
    chk(bus_rdata, VM, "R10 raw");
    do_write(5, 32'hFFFF_FFFF);
    do_write(3, 32'hFFFF_FFFF);
    // R10: unused source positions alone raise nothing
    do_write(2, 32'hFFFF_FFFF);
    do_src(~VM);
    chk({31'b0, irq_o}, 32'd0, "R10 irq");
    do_write(3, 32'hFFFF_FFFF);

    // random mix
    for (int i = 0; i < 300; i++) begin
      int a;
      logic [31:0] d;
      a = int'($urandom_range(0, 15));
      d = $urandom();
      if ($urandom_range(0, 3) == 0) d = 32'(1) << $urandom_range(0, 31);
      if ($urandom_range(0, 2) == 0) do_src($urandom() & $urandom());
      do_write(a, d);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule